// File: doc/BRIEF.md
# Expansion Cartridge Address Decoder

This block sits inside a plug-in cartridge on a console's parallel expansion bus. The CPU issues byte-wide read and write strobes with an offset relative to the expansion base (0x1F000000). The block turns each access into one of three things: a chip select for one of two 128 KB flash banks, a read of a link or switch status bit, or an access to the serial link data path. The flash devices sit outside the block. It drives their chip selects, read and write enables and a 17-bit local address, and it passes the flash read data back onto the bus.

The link side brings the partner's strobe and the panel switch through two-flop synchronisers. It captures the partner's data byte on each rising edge of the synchronised strobe. A CPU write to the transmit offset latches a byte onto the link output. The same write starts an acknowledge pulse that a small state machine produces. The machine has two states, ACK_IDLE and ACK_HOLD. The transition ACK_IDLE to ACK_HOLD is taken on a transmit write. ACK_HOLD to ACK_HOLD reloads the counter on a new transmit write, and otherwise counts down. ACK_HOLD to ACK_IDLE is taken when the counter reaches zero.

Top module: `exp_cart_decoder`

## Requirements
- R1: While reset is held and after its release, the link output byte is 0x00 and the acknowledge line is low.
- R2: A read or write at offsets 0x00000–0x1FFFF asserts the bank-0 chip select in the same cycle. `flash_addr` equals offset bits [16:0], `flash_oe` follows a read, `flash_we` follows a write, and a read returns `flash_rdata`.
- R3: A read or write at offsets 0x40000–0x5FFFF asserts the bank-1 chip select in the same way, with `flash_addr` equal to offset bits [16:0].
- R4: At most one chip select is active in any cycle. Neither is active without a strobe.
- R5: A read at offset 0x20010 returns the link strobe level in bit 0 and zeros in bits 7:1. The level is seen two clocks after the pin changes.
- R6: A read at offset 0x20018 returns the switch position in bit 0 (1 = on, 0 = off) and zeros in bits 7:1, with the same two-clock synchroniser latency.
- R7: A read at offset 0x60000 returns the link input byte as it stood on the most recent rising edge of the synchronised strobe.
- R8: A write at offset 0x60008 puts the written byte on `link_tx` at the next clock edge. The byte holds until the next such write.
- R9: The acknowledge line goes high on the clock after the transmit write is sampled and stays high for ACK_LEN clocks (default 4). A transmit write during the pulse restarts the full ACK_LEN count.
- R10: A read at any unmapped offset, including the transmit offset, returns 0xFF with no chip select asserted.
- R11: Writes to offsets 0x20010, 0x20018 and 0x60000 are ignored. `link_tx` keeps its value, no acknowledge pulse starts and no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 19 | Offset from expansion base |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| flash_cs0 | output | 1 | Bank-0 chip select |
| flash_cs1 | output | 1 | Bank-1 chip select |
| flash_addr | output | 17 | Local flash address |
| flash_oe | output | 1 | Flash read enable |
| flash_we | output | 1 | Flash write enable |
| flash_rdata | input | 8 | Data returned by the selected bank |
| link_stb | input | 1 | Strobe from the link partner |
| panel_sw | input | 1 | Front-panel switch |
| link_rx | input | 8 | Link data from partner |
| link_tx | output | 8 | Link data to partner |
| link_ack | output | 1 | Acknowledge pulse to partner |

## Verification
Several properties are checked on every cycle. The chip selects must never overlap. The acknowledge line must equal a window of ACK_LEN clocks that restarts at each transmit write. The transmit byte may change only at a transmit write. Unmapped reads must return 0xFF. Only the directed scenarios can show the rest: the address ranges of each bank, the synchroniser latency of the status bits, the byte captured on a strobe edge, and the ignored writes to the status offsets.

// File: rtl/exp_cart_pkg.sv
package exp_cart_pkg;
    localparam int ADDR_W  = 19;
    localparam int DATA_W  = 8;
    localparam int FADDR_W = 17;

    localparam logic [ADDR_W-1:0] OFS_STB = 19'h20010;
    localparam logic [ADDR_W-1:0] OFS_SW  = 19'h20018;
    localparam logic [ADDR_W-1:0] OFS_RX  = 19'h60000;
    localparam logic [ADDR_W-1:0] OFS_TX  = 19'h60008;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK0,
        SEL_BANK1,
        SEL_STB,
        SEL_SW,
        SEL_RX,
        SEL_TX
    } sel_e;

    typedef enum logic {
        ACK_IDLE,
        ACK_HOLD
    } ack_state_e;
endpackage

// File: rtl/exp_addr_decode.sv
module exp_addr_decode
    import exp_cart_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int BANK_MSB = ADDR_W - 1;
    localparam int BANK_LSB = FADDR_W;

    logic [BANK_MSB-BANK_LSB:0] window;
    assign window = addr[BANK_MSB:BANK_LSB];

    always_comb begin
        sel = SEL_NONE;
        if (window == 2'b00)       sel = SEL_BANK0;
        else if (window == 2'b10)  sel = SEL_BANK1;
        else if (addr == OFS_STB)  sel = SEL_STB;
        else if (addr == OFS_SW)   sel = SEL_SW;
        else if (addr == OFS_RX)   sel = SEL_RX;
        else if (addr == OFS_TX)   sel = SEL_TX;
    end
endmodule

// File: rtl/exp_link_port.sv
module exp_link_port
    import exp_cart_pkg::*;
#(
    parameter int ACK_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_pin,
    input  logic              sw_pin,
    input  logic [DATA_W-1:0] rx_pin,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              stb_lvl,
    output logic              sw_lvl,
    output logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] tx_byte,
    output logic              ack
);
    localparam int CNT_W = $clog2(ACK_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_LEN - 1);

    logic [1:0] stb_sync, sw_sync;
    logic       stb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_sync <= '0;
            sw_sync  <= '0;
            stb_prev <= 1'b0;
            rx_byte  <= '0;
        end else begin
            stb_sync <= {stb_sync[0], stb_pin};
            sw_sync  <= {sw_sync[0], sw_pin};
            stb_prev <= stb_sync[1];
            if (stb_sync[1] && !stb_prev) rx_byte <= rx_pin;
        end
    end

    assign stb_lvl = stb_sync[1];
    assign sw_lvl  = sw_sync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tx_byte <= '0;
        else if (tx_wr) tx_byte <= tx_data;
    end

    ack_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ACK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ACK_IDLE: begin
                if (tx_wr) begin
                    state_nx = ACK_HOLD;
                    cnt_nx   = CNT_LOAD;
                end
            end
            ACK_HOLD: begin
                if (tx_wr) begin
                    cnt_nx = CNT_LOAD;
                end else if (cnt == '0) begin
                    state_nx = ACK_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: state_nx = ACK_IDLE;
        endcase
    end

    always_comb begin
        ack = (state == ACK_HOLD);
    end

    // Window tracker for the acknowledge check
    localparam int SW_W = $clog2(ACK_LEN + 1) + 1;
    logic [SW_W-1:0] since_wr;
    logic            seen_wr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_wr <= '0;
            seen_wr  <= 1'b0;
        end else if (tx_wr) begin
            since_wr <= '0;
            seen_wr  <= 1'b1;
        end else if (since_wr < SW_W'(ACK_LEN)) begin
            since_wr <= since_wr + 1'b1;
        end
    end

    // R9: acknowledge high exactly for ACK_LEN clocks after the latest transmit write
    a_r9_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
        ack == (seen_wr && (since_wr < SW_W'(ACK_LEN))));

    // R8: the transmit byte changes only at a transmit write
    a_r8_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_wr |=> $stable(tx_byte));

    // R9: a rising acknowledge always follows a transmit write
    a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(tx_wr));
endmodule

// File: rtl/exp_cart_decoder.sv
module exp_cart_decoder
    import exp_cart_pkg::*;
#(
    parameter int ACK_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                flash_cs0,
    output logic                flash_cs1,
    output logic [FADDR_W-1:0]  flash_addr,
    output logic                flash_oe,
    output logic                flash_we,
    input  logic [DATA_W-1:0]   flash_rdata,
    input  logic                link_stb,
    input  logic                panel_sw,
    input  logic [DATA_W-1:0]   link_rx,
    output logic [DATA_W-1:0]   link_tx,
    output logic                link_ack
);
    sel_e sel;
    logic stb_lvl, sw_lvl, tx_wr, acc;
    logic [DATA_W-1:0] rx_byte;

    exp_addr_decode i_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign acc   = bus_rd | bus_wr;
    assign tx_wr = bus_wr && (sel == SEL_TX);

    exp_link_port #(.ACK_LEN(ACK_LEN)) i_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_pin (link_stb),
        .sw_pin  (panel_sw),
        .rx_pin  (link_rx),
        .tx_wr   (tx_wr),
        .tx_data (bus_wdata),
        .stb_lvl (stb_lvl),
        .sw_lvl  (sw_lvl),
        .rx_byte (rx_byte),
        .tx_byte (link_tx),
        .ack     (link_ack)
    );

    always_comb begin
        flash_cs0  = acc && (sel == SEL_BANK0);
        flash_cs1  = acc && (sel == SEL_BANK1);
        flash_addr = bus_addr[FADDR_W-1:0];
        flash_oe   = bus_rd && (flash_cs0 || flash_cs1);
        flash_we   = bus_wr && (flash_cs0 || flash_cs1);
    end

    always_comb begin
        bus_rdata = '1;
        if (bus_rd) begin
            unique case (sel)
                SEL_BANK0, SEL_BANK1: bus_rdata = flash_rdata;
                SEL_STB:              bus_rdata = {{(DATA_W-1){1'b0}}, stb_lvl};
                SEL_SW:               bus_rdata = {{(DATA_W-1){1'b0}}, sw_lvl};
                SEL_RX:               bus_rdata = rx_byte;
                default:              bus_rdata = '1;
            endcase
        end
    end

    // R4: chip selects never overlap
    a_r4_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_cs0, flash_cs1}));

    // R4: no chip select without a strobe
    a_r4_cs_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> !(flash_cs0 || flash_cs1));

    // R10: a read that reaches no bank and no register gives all ones
    a_r10_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_NONE || sel == SEL_TX)) |-> (bus_rdata == 8'hFF && !flash_cs0 && !flash_cs1));
endmodule

// File: tb/test_exp_cart_decoder.sv
module test_exp_cart_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ACK_LEN    = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        flash_cs0, flash_cs1, flash_oe, flash_we;
    logic [16:0] flash_addr;
    logic [7:0]  flash_rdata;
    logic        link_stb, panel_sw;
    logic [7:0]  link_rx, link_tx;
    logic        link_ack;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_cart_decoder #(.ACK_LEN(ACK_LEN)) i_exp_cart_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_cs0(flash_cs0), .flash_cs1(flash_cs1), .flash_addr(flash_addr),
        .flash_oe(flash_oe), .flash_we(flash_we), .flash_rdata(flash_rdata),
        .link_stb(link_stb), .panel_sw(panel_sw), .link_rx(link_rx),
        .link_tx(link_tx), .link_ack(link_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [18:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        #1;
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        #1;
    endtask

    task automatic count_ack(output int n);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (link_ack !== 1'b1) break;
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset();
        chk("R1 tx after reset", link_tx, 8'h00);
        chk("R1 ack after reset", link_ack, 1'b0);
        chk("R4 no cs idle", {flash_cs0, flash_cs1}, 2'b00);
    endtask

    task automatic t_bank0();
        flash_rdata = 8'h3C;
        do_read(19'h1ABCD);
        chk("R2 cs0 read", {flash_cs0, flash_cs1, flash_oe, flash_we}, 4'b1010);
        chk("R2 addr", flash_addr, 17'h1ABCD);
        chk("R2 rdata", bus_rdata, 8'h3C);
        do_write(19'h00000, 8'h11);
        chk("R2 cs0 write", {flash_cs0, flash_cs1, flash_oe, flash_we}, 4'b1001);
        do_read(19'h1FFFF);
        chk("R2 top edge", flash_cs0, 1'b1);
        idle_bus();
    endtask

    task automatic t_bank1();
        flash_rdata = 8'hC3;
        do_read(19'h40000);
        chk("R3 cs1 read", {flash_cs0, flash_cs1, flash_oe, flash_we}, 4'b0110);
        chk("R3 addr", flash_addr, 17'h00000);
        chk("R3 rdata", bus_rdata, 8'hC3);
        do_write(19'h5FFFF, 8'h22);
        chk("R3 cs1 write", {flash_cs0, flash_cs1, flash_oe, flash_we}, 4'b0101);
        chk("R3 addr hi", flash_addr, 17'h1FFFF);
        idle_bus();
    endtask

    task automatic t_unmapped();
        do_read(19'h20000);
        chk("R10 gap rdata", bus_rdata, 8'hFF);
        chk("R10 gap cs", {flash_cs0, flash_cs1}, 2'b00);
        do_read(19'h60008);
        chk("R10 tx read", bus_rdata, 8'hFF);
        do_read(19'h7FFFF);
        chk("R10 high rdata", bus_rdata, 8'hFF);
        do_read(19'h20014);
        chk("R10 near stb", bus_rdata, 8'hFF);
        idle_bus();
        @(negedge clk); #1;
        chk("R4 no cs without strobe", {flash_cs0, flash_cs1}, 2'b00);
    endtask

    task automatic t_status();
        @(negedge clk);
        link_stb = 1; panel_sw = 1;
        do_read(19'h20010);
        chk("R5 one clock late", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R5 strobe high", bus_rdata, 8'h01);
        bus_addr = 19'h20018; #1;
        chk("R6 switch on", bus_rdata, 8'h01);
        panel_sw = 0;
        repeat (2) @(negedge clk);
        #1;
        chk("R6 switch off", bus_rdata, 8'h00);
        link_stb = 0;
        repeat (2) @(negedge clk);
        bus_addr = 19'h20010; #1;
        chk("R5 strobe low", bus_rdata, 8'h00);
        idle_bus();
    endtask

    task automatic t_rx();
        @(negedge clk);
        link_rx = 8'hA5; link_stb = 1;
        repeat (4) @(negedge clk);
        link_rx = 8'h5A;
        do_read(19'h60000);
        chk("R7 captured byte", bus_rdata, 8'hA5);
        link_stb = 0;
        repeat (4) @(negedge clk);
        #1;
        chk("R7 held after fall", bus_rdata, 8'hA5);
        link_stb = 1;
        repeat (4) @(negedge clk);
        #1;
        chk("R7 next edge", bus_rdata, 8'h5A);
        link_stb = 0;
        idle_bus();
    endtask

    task automatic t_tx_ack();
        int n;
        do_write(19'h60008, 8'h9E);
        chk("R9 ack not before edge", link_ack, 1'b0);
        @(negedge clk);
        idle_bus(); #1;
        chk("R8 tx latched", link_tx, 8'h9E);
        count_ack(n);
        chk("R9 ack length", n, ACK_LEN);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 tx holds", link_tx, 8'h9E);
    endtask

    task automatic t_ack_restart();
        int n;
        do_write(19'h60008, 8'h01);
        @(negedge clk);
        idle_bus();
        @(negedge clk);
        do_write(19'h60008, 8'h02);
        @(negedge clk);
        idle_bus(); #1;
        chk("R8 second byte", link_tx, 8'h02);
        count_ack(n);
        chk("R9 restarted length", n, ACK_LEN);
    endtask

    task automatic t_ro_writes();
        do_write(19'h20010, 8'h77);
        chk("R11 stb write no cs", {flash_cs0, flash_cs1}, 2'b00);
        do_write(19'h20018, 8'h77);
        do_write(19'h60000, 8'h77);
        chk("R11 rx write no cs", {flash_cs0, flash_cs1}, 2'b00);
        @(negedge clk);
        idle_bus();
        repeat (2) @(negedge clk);
        #1;
        chk("R11 tx unchanged", link_tx, 8'h02);
        chk("R11 no ack", link_ack, 1'b0);
        do_read(19'h60000);
        chk("R11 rx unchanged", bus_rdata, 8'h5A);
        idle_bus();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; idle_bus();
        flash_rdata = 8'h00; link_stb = 0; panel_sw = 0; link_rx = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_bank0();
        t_bank1();
        t_unmapped();
        t_status();
        t_rx();
        t_tx_ack();
        t_ack_restart();
        t_ro_writes();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule